// File: doc/BRIEF.md
# I2C Status and Control Register

This block holds the eight-bit status and control word that the master and slave halves of an I2C controller share. The shifter, bus drivers and condition detectors around it report their events as single-cycle strobes: an illegally placed start or stop, a stop, a start, lost arbitration, a received address byte, a finished byte, and the sampled acknowledge bit. Firmware reaches the register through a byte-wide write port. It also sends a one-cycle strobe when it writes the start or restart generate bits of the master command register, together with a master-mode qualifier.

Each bit has its own owner and its own set and clear rules. Four flags are sticky: hardware sets them, and only a firmware write of zero clears them. Three bits are cleared when the bus restarts. The acknowledge-out bit belongs to firmware, and hardware drops it after every byte. The finished-byte flag drives the interrupt request. Lost arbitration is recorded but does not raise the interrupt. While the global enable is low, the whole word is held at zero.

Top module: `i2c_scr_reg`

## Requirements
- R1: While `cfg_enable` is 0, every bit clears at the next clock edge and stays 0 regardless of events or writes. Reset (`rst_n` low) also clears all bits and `irq`.
- R2: The `scr_q` bit layout is fixed: 7 bus error, 6 lost arbitration, 5 stop seen, 4 acknowledge out, 3 address, 2 transmit, 1 last received bit, 0 byte complete.
- R3: Bit 7 sets on `evt_bus_err`. Only a write whose data bit 7 is 0 clears it, and a write with a 1 there leaves it unchanged.
- R4: Bit 5 sets on `evt_stop`. Only a write with data bit 5 at 0 clears it, and writing 1 has no effect.
- R5: Bit 3 sets on `evt_addr`. Only a write with data bit 3 at 0 clears it, and writing 1 has no effect.
- R6: Bit 0 sets on `evt_byte_done` and is cleared by a write with data bit 0 at 0. `irq` is 1 exactly while bit 0 is 1.
- R7: When a sticky flag's set event and a clearing write fall in the same cycle, the flag ends up 1.
- R8: Bit 6 sets on `evt_arb_lost` without raising `irq`. It clears on `evt_start`, or on `gen_start_wr` while `master_mode` is 1. Writes do not affect it, and a set in the same cycle as a clear wins.
- R9: Bit 2 takes data bit 2 on every write. It clears on `evt_start`, or on `gen_start_wr` while `master_mode` is 1. A write in the same cycle as such a clear wins.
- R10: Bit 4 takes data bit 4 on every write and clears on `evt_byte_done`. A write in the same cycle as byte done wins.
- R11: Bit 1 loads `ack_level` when `ack_sample` is 1. It clears on `evt_start`, or on `gen_start_wr` while `master_mode` is 1, and a capture in the same cycle as such a clear wins. Writes do not affect it.
- R12: `gen_start_wr` with `master_mode` at 0 changes no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | OR of the configuration enables; low holds all bits at zero |
| evt_bus_err | input | 1 | Misplaced start or stop strobe |
| evt_stop | input | 1 | Stop condition strobe |
| evt_start | input | 1 | Start condition strobe |
| evt_arb_lost | input | 1 | Arbitration lost strobe |
| evt_addr | input | 1 | Received byte was an address |
| evt_byte_done | input | 1 | Byte transfer finished strobe |
| ack_sample | input | 1 | Ninth bit sampled strobe |
| ack_level | input | 1 | Sampled ninth bit, 1 means NAK |
| wr_en | input | 1 | Firmware write strobe |
| wr_data | input | 8 | Firmware write data |
| gen_start_wr | input | 1 | Firmware wrote the start or restart generate bits |
| master_mode | input | 1 | Block is operating as master |
| scr_q | output | 8 | Register contents |
| irq | output | 1 | Byte complete interrupt request |

## Verification
Most bits have a hardware source and a firmware source that can land in the same cycle. The cases covered are a bus error arriving with a write of zero, a lost arbitration arriving with a start, a byte done arriving with an acknowledge write, a transmit write arriving with a master restart strobe, and an acknowledge capture arriving with a start. The bench drives both strobes in one vector and checks that the winner named in the requirement shows on `scr_q` one edge later. It also drives the inputs that must be ignored, namely writes of 1 to clear-only bits, slave-mode restart strobes and events while disabled, and confirms that the word is unchanged.

// File: rtl/i2c_scr_pkg.sv
package i2c_scr_pkg;
    localparam int SCR_W = 8;

    // bit positions, fixed by the register layout (R2)
    localparam int POS_BUS_ERR = 7;
    localparam int POS_ARB     = 6;
    localparam int POS_STOP    = 5;
    localparam int POS_ACK     = 4;
    localparam int POS_ADDR    = 3;
    localparam int POS_XMIT    = 2;
    localparam int POS_LRB     = 1;
    localparam int POS_BDONE   = 0;

    // sticky flags: set by hardware, cleared by a firmware write of zero
    localparam int NUM_STICKY = 4;

    typedef struct packed {
        logic bus_err;
        logic arb_lost;
        logic stop_seen;
        logic ack_out;
        logic addr_match;
        logic xmit;
        logic last_rx_bit;
        logic byte_done;
    } scr_t;
endpackage

// File: rtl/scr_sticky_flag.sv
module scr_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_clr,
    input  logic set_evt,
    input  logic wr_en,
    input  logic wr_bit,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= 1'b0;
        else if (hold_clr)
            q <= 1'b0;
        else if (set_evt)
            q <= 1'b1;           // set beats a same-cycle clear
        else if (wr_en && !wr_bit)
            q <= 1'b0;           // a written 1 leaves the flag alone
    end
endmodule

// File: rtl/scr_prio_bit.sv
module scr_prio_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_clr,
    input  logic set_evt,
    input  logic load_evt,
    input  logic load_val,
    input  logic clr_evt,
    output logic q
);
    // priority: hold > set > load > clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= 1'b0;
        else if (hold_clr)
            q <= 1'b0;
        else if (set_evt)
            q <= 1'b1;
        else if (load_evt)
            q <= load_val;
        else if (clr_evt)
            q <= 1'b0;
    end
endmodule

// File: rtl/i2c_scr_reg.sv
module i2c_scr_reg
    import i2c_scr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_enable,
    input  logic             evt_bus_err,
    input  logic             evt_stop,
    input  logic             evt_start,
    input  logic             evt_arb_lost,
    input  logic             evt_addr,
    input  logic             evt_byte_done,
    input  logic             ack_sample,
    input  logic             ack_level,
    input  logic             wr_en,
    input  logic [SCR_W-1:0] wr_data,
    input  logic             gen_start_wr,
    input  logic             master_mode,
    output logic [SCR_W-1:0] scr_q,
    output logic             irq
);
    localparam int STK_POS [NUM_STICKY] = '{POS_BUS_ERR, POS_STOP, POS_ADDR, POS_BDONE};

    logic                  hold;
    logic                  restart_clr;
    logic [NUM_STICKY-1:0] stk_set;
    logic [NUM_STICKY-1:0] stk_q;
    logic                  arb_q, ack_q, xmit_q, lrb_q;
    scr_t                  word;

    always_comb begin
        hold        = !cfg_enable;
        restart_clr = evt_start || (gen_start_wr && master_mode);
        stk_set     = {evt_bus_err, evt_stop, evt_addr, evt_byte_done};
    end

    for (genvar i = 0; i < NUM_STICKY; i++) begin : g_sticky
        scr_sticky_flag u_flag (
            .clk      (clk),
            .rst_n    (rst_n),
            .hold_clr (hold),
            .set_evt  (stk_set[NUM_STICKY-1-i]),
            .wr_en    (wr_en),
            .wr_bit   (wr_data[STK_POS[i]]),
            .q        (stk_q[NUM_STICKY-1-i])
        );
    end

    scr_prio_bit u_arb (
        .clk(clk), .rst_n(rst_n), .hold_clr(hold),
        .set_evt(evt_arb_lost), .load_evt(1'b0), .load_val(1'b0),
        .clr_evt(restart_clr), .q(arb_q)
    );

    scr_prio_bit u_ack (
        .clk(clk), .rst_n(rst_n), .hold_clr(hold),
        .set_evt(1'b0), .load_evt(wr_en), .load_val(wr_data[POS_ACK]),
        .clr_evt(evt_byte_done), .q(ack_q)
    );

    scr_prio_bit u_xmit (
        .clk(clk), .rst_n(rst_n), .hold_clr(hold),
        .set_evt(1'b0), .load_evt(wr_en), .load_val(wr_data[POS_XMIT]),
        .clr_evt(restart_clr), .q(xmit_q)
    );

    scr_prio_bit u_lrb (
        .clk(clk), .rst_n(rst_n), .hold_clr(hold),
        .set_evt(1'b0), .load_evt(ack_sample), .load_val(ack_level),
        .clr_evt(restart_clr), .q(lrb_q)
    );

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[POS_ARB], wr_data[POS_LRB]};

    always_comb begin
        word.bus_err     = stk_q[3];
        word.arb_lost    = arb_q;
        word.stop_seen   = stk_q[2];
        word.ack_out     = ack_q;
        word.addr_match  = stk_q[1];
        word.xmit        = xmit_q;
        word.last_rx_bit = lrb_q;
        word.byte_done   = stk_q[0];
        scr_q            = word;
        irq              = word.byte_done;
    end
endmodule

// File: rtl/i2c_scr_checker.sv
module i2c_scr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_enable,
    input logic       evt_bus_err,
    input logic       evt_start,
    input logic       evt_arb_lost,
    input logic       evt_byte_done,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       gen_start_wr,
    input logic       master_mode,
    input logic [7:0] scr_q,
    input logic       irq
);
    assert_hold_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> scr_q == 8'h00);

    assert_buserr_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && evt_bus_err) |=> scr_q[7]);

    assert_buserr_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && scr_q[7] && !(wr_en && !wr_data[7])) |=> scr_q[7]);

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && evt_byte_done && wr_en && !wr_data[0]) |=> scr_q[0]);

    assert_arb_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && evt_arb_lost && !evt_byte_done && !scr_q[0]) |=> !irq);

    assert_arb_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && !evt_arb_lost && (evt_start || (gen_start_wr && master_mode)))
        |=> !scr_q[6]);

    assert_ack_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && evt_byte_done && !wr_en) |=> !scr_q[4]);

    assert_slave_gen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && scr_q[6] && gen_start_wr && !master_mode && !evt_start)
        |=> scr_q[6]);
endmodule

bind i2c_scr_reg i2c_scr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
    .evt_bus_err(evt_bus_err), .evt_start(evt_start),
    .evt_arb_lost(evt_arb_lost), .evt_byte_done(evt_byte_done),
    .wr_en(wr_en), .wr_data(wr_data), .gen_start_wr(gen_start_wr),
    .master_mode(master_mode), .scr_q(scr_q), .irq(irq)
);

// File: tb/i2c_scr_reg_test.sv
module i2c_scr_reg_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_enable, evt_bus_err, evt_stop, evt_start, evt_arb_lost;
    logic       evt_addr, evt_byte_done, ack_sample, ack_level;
    logic       wr_en, gen_start_wr, master_mode;
    logic [7:0] wr_data;
    logic [7:0] scr_q;
    logic       irq;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    i2c_scr_reg uut (.*);

    // event field: [11]en [10]bus_err [9]stop [8]start [7]arb [6]addr
    //              [5]byte_done [4]ack_sample [3]ack_level [2]wr [1]gen [0]master
    // vector: {events[11:0], wr_data, expected scr_q, requirement number}
    localparam int NV = 22;
    localparam logic [35:0] VEC [NV] = '{
        {12'h800, 8'h00, 8'h00, 8'd1},   // R1 enabled idle
        {12'hC00, 8'h00, 8'h80, 8'd3},   // R3 bus error sets
        {12'h804, 8'h80, 8'h80, 8'd3},   // R3 write 1 ignored
        {12'h804, 8'h00, 8'h00, 8'd3},   // R3 write 0 clears
        {12'hA00, 8'h00, 8'h20, 8'd4},   // R4 stop sets
        {12'h840, 8'h00, 8'h28, 8'd5},   // R5 address sets
        {12'h804, 8'hDF, 8'h1C, 8'd4},   // R4 clear, R5 kept, R9/R10 load
        {12'h820, 8'h00, 8'h0D, 8'd6},   // R6 byte done sets, R10 ack cleared
        {12'h804, 8'hFE, 8'h1C, 8'd6},   // R6 cleared by write 0
        {12'h880, 8'h00, 8'h5C, 8'd8},   // R8 arbitration lost, no irq
        {12'h802, 8'h00, 8'h5C, 8'd12},  // R12 slave restart strobe ignored
        {12'h818, 8'h00, 8'h5E, 8'd11},  // R11 NAK captured
        {12'h900, 8'h00, 8'h18, 8'd11},  // R11/R8/R9 start clears
        {12'h980, 8'h00, 8'h58, 8'd8},   // R8 set beats start
        {12'h803, 8'h00, 8'h18, 8'd8},   // R8 master restart clears
        {12'hC04, 8'h00, 8'h80, 8'd7},   // R7 set beats write 0
        {12'h807, 8'h14, 8'h14, 8'd9},   // R9 write beats restart clear
        {12'h824, 8'h10, 8'h11, 8'd10},  // R10 write beats byte done
        {12'h918, 8'h00, 8'h13, 8'd11},  // R11 capture beats start
        {12'h400, 8'h00, 8'h00, 8'd1},   // R1 disabled clears
        {12'h004, 8'hFF, 8'h00, 8'd1},   // R1 disabled ignores write
        {12'h800, 8'h00, 8'h00, 8'd1}    // R1 re-enabled, still zero
    };

    task automatic drive(input logic [11:0] ev, input logic [7:0] wd);
        {cfg_enable, evt_bus_err, evt_stop, evt_start, evt_arb_lost, evt_addr,
         evt_byte_done, ack_sample, ack_level, wr_en, gen_start_wr, master_mode} = ev;
        wr_data = wd;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    initial begin
        drive(12'h800, 8'h00);
        #12;
        check("R1 reset word", scr_q, 8'h00);
        check("R1 reset irq", {7'd0, irq}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][35:24], VEC[i][23:16]);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VEC[i][7:0], i), scr_q, VEC[i][15:8]);
            check($sformatf("R6 irq vector %0d", i), {7'd0, irq}, {7'd0, VEC[i][8]});
        end
        // R2: each flag lands in its own bit position
        drive(12'hA00, 8'h00); @(negedge clk);
        check("R2 stop at bit 5", scr_q, 8'h20);
        drive(12'h804, 8'h00); @(negedge clk);
        drive(12'h840, 8'h00); @(negedge clk);
        check("R2 address at bit 3", scr_q, 8'h08);
        // R1: asynchronous reset mid-run
        drive(12'hC20, 8'h00); @(negedge clk);
        check("R1 pre-reset", scr_q, 8'h89);
        drive(12'h800, 8'h00);
        rst_n = 1'b0; #1;
        check("R1 async reset word", scr_q, 8'h00);
        check("R1 async reset irq", {7'd0, irq}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule